// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits at the clock output stage of a system clock generator. It gates two independent groups of clock outputs in response to asynchronous, active-low stop requests. The processor group covers the processor and memory clock lanes and runs from the processor reference clock. The peripheral group covers the peripheral bus lanes and runs from the peripheral reference clock. Each request passes through a synchronizer in its own domain and then through a small sequencer. The sequencer imposes a fixed number of reference edges before a gate closes or opens, and it keeps a restarted group running for a minimum number of cycles.

Each lane's enable is captured on the falling edge of its reference clock and combined with that clock. A lane therefore switches only while the clock is low. A stopped lane rests at 0, and the first high phase after a restart has full width. A static strap input decides whether lane 0 of the processor bank and lane 0 of the memory bank obey the stop request or run freely. One peripheral output is never gated. A stop request that arrives while the minimum-run window is still open is not lost. The request is a level, so it takes effect as soon as the window closes, provided it is still asserted. There is no data flow, so there is no valid/ready interface. All pins are plain control or clock signals.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, every gated output is held at 0. After release, each group follows its reference clock.
- R2: Suppose `cpu_stop_n` falls during a low phase of the processor reference clock while the group's run window is complete. Every stoppable processor and memory lane then shows exactly SYNC_STAGES + CPU_OFF_LAT (default 3) further high pulses and then stays low.
- R3: Every stopped lane stays at 0 in every high phase of its reference clock for as long as its group is stopped.
- R4: Suppose `cpu_stop_n` rises during a low phase. The first high pulse of the processor group then starts on rising edge SYNC_STAGES + CPU_ON_LAT + 1 (default 4) counted after the release, so there are fewer than 4 dead processor clocks.
- R5: The first high pulse after a restart is a full half period of the reference clock.
- R6: After a processor restart the group runs at least CPU_MIN_ON (default 100) cycles. A stop held asserted from within that window takes effect at its end, so the group delivers exactly CPU_MIN_ON + CPU_OFF_LAT (default 101) pulses counted from the first pulse of the restart.
- R7: When `lane0_gated` is 0, `cpu_clk_out[0]` and `sdram_clk_out[0]` keep running during a processor stop. When it is 1, they stop with the rest of the group.
- R8: In the peripheral group a stop gives exactly SYNC_STAGES + PCI_OFF_LAT (default 3) further pulses. This is one peripheral clock after synchronization. On release, the first pulse starts on rising edge SYNC_STAGES + PCI_ON_LAT + 1 (default 6), which is three rising edges after synchronization.
- R9: After a peripheral restart the group delivers exactly PCI_MIN_ON + PCI_OFF_LAT (default 11) pulses before a stop held from within the window takes effect.
- R10: `pci_free_clk_out` never stops. A stop of either group leaves every output of the other group running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_ref_clk | input | 1 | Processor-domain reference clock |
| pci_ref_clk | input | 1 | Peripheral-domain reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized per domain on release |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for the processor and memory lanes |
| pci_stop_n | input | 1 | Asynchronous active-low stop request for the peripheral lanes |
| lane0_gated | input | 1 | Static strap: 1 makes processor lane 0 and memory lane 0 stoppable, 0 keeps them free-running |
| cpu_clk_out | output | N_CPU | Gated processor clock lanes |
| sdram_clk_out | output | N_SDRAM | Gated memory clock lanes |
| pci_clk_out | output | N_PCI | Gated peripheral clock lanes |
| pci_free_clk_out | output | 1 | Ungated peripheral clock |

## Verification
Suppose a sequencer state or counter goes wrong. The pulse count after a request edge then differs from the fixed latency, and this shows at the outputs within a handful of reference edges. A failure to hold a pending stop shows as a pulse count far from CPU_MIN_ON + CPU_OFF_LAT. If an enable flop is captured on the wrong edge, the first restart pulse is shortened, which a width measurement of that pulse exposes at once. A wrong lane mask shows as a strap-selected lane stopping, or failing to stop, within the first stopped cycle.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // Sequencer states of one stop channel
  typedef enum logic [1:0] {
    CH_RUN   = 2'd0,  // gates open, run window counting
    CH_DRAIN = 2'd1,  // stop seen, counting off latency
    CH_HALT  = 2'd2,  // gates closed
    CH_WAKE  = 2'd3   // release seen, counting on latency
  } ch_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with a selectable reset value.
module clkstop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_seq.sv
`timescale 1ns/1ps
// Stop/start sequencer: counts off and on latency, enforces the run window.
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int OFF_LAT = 1,
  parameter int ON_LAT  = 1,
  parameter int MIN_ON  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  output logic run
);

  localparam int LAT_MAX = max2(OFF_LAT, ON_LAT);
  localparam int CW      = $clog2(LAT_MAX + 1);
  localparam int WW      = $clog2(MIN_ON + 2);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_LAT - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_LAT - 1);
  localparam logic [CW-1:0] LAT_ONE  = CW'(1);
  localparam logic [WW-1:0] WIN_FULL = WW'(MIN_ON);

  ch_state_e       st_q, st_d;
  logic [CW-1:0]   lat_q, lat_d;
  logic [WW-1:0]   win_q, win_d;
  logic            win_done;
  logic            open_st;

  assign win_done = (win_q == WIN_FULL);
  assign open_st  = (st_q == CH_RUN) || (st_q == CH_DRAIN);

  always_comb begin
    st_d  = st_q;
    lat_d = lat_q;
    win_d = win_q;
    if (open_st && !win_done) win_d = win_q + WW'(1);
    unique case (st_q)
      CH_RUN: begin
        if (stop_req && win_done) begin
          if (OFF_LAT <= 1) begin
            st_d = CH_HALT;
          end else begin
            st_d  = CH_DRAIN;
            lat_d = LAT_ONE;
          end
        end
      end
      CH_DRAIN: begin
        if (!stop_req)              st_d = CH_RUN;
        else if (lat_q == OFF_LAST) st_d = CH_HALT;
        else                        lat_d = lat_q + CW'(1);
      end
      CH_HALT: begin
        if (!stop_req) begin
          if (ON_LAT <= 1) begin
            st_d  = CH_RUN;
            win_d = '0;
          end else begin
            st_d  = CH_WAKE;
            lat_d = LAT_ONE;
          end
        end
      end
      CH_WAKE: begin
        if (stop_req) begin
          st_d = CH_HALT;
        end else if (lat_q == ON_LAST) begin
          st_d  = CH_RUN;
          win_d = '0;
        end else begin
          lat_d = lat_q + CW'(1);
        end
      end
      default: st_d = CH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_RUN;
      lat_q <= '0;
      win_q <= WIN_FULL;
    end else begin
      st_q  <= st_d;
      lat_q <= lat_d;
      win_q <= win_d;
    end
  end

  assign run = open_st;

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
// Per-lane clock gates: enable captured while the clock is low.
module clkstop_gate #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LANES-1:0] exempt,
  output logic [LANES-1:0] clk_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic en_q;

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= run;
    end

    assign clk_out[g] = exempt[g] ? clk : (clk & en_q);
  end

endmodule

// File: rtl/clkstop_channel.sv
`timescale 1ns/1ps
// One stop channel: reset sync, request sync, sequencer, gate bank.
module clkstop_channel #(
  parameter int SYNC_STAGES = 2,
  parameter int OFF_LAT     = 1,
  parameter int ON_LAT      = 1,
  parameter int MIN_ON      = 100,
  parameter int LANES       = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             stop_n,
  input  logic [LANES-1:0] exempt,
  output logic [LANES-1:0] clk_out,
  output logic             run
);

  logic dom_rst_n;
  logic stop_n_sync;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .async_in (1'b1),
    .sync_out (dom_rst_n)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk      (ref_clk),
    .rst_n    (dom_rst_n),
    .async_in (stop_n),
    .sync_out (stop_n_sync)
  );

  clkstop_seq #(.OFF_LAT(OFF_LAT), .ON_LAT(ON_LAT), .MIN_ON(MIN_ON)) u_seq (
    .clk      (ref_clk),
    .rst_n    (dom_rst_n),
    .stop_req (!stop_n_sync),
    .run      (run)
  );

  clkstop_gate #(.LANES(LANES)) u_gate (
    .clk     (ref_clk),
    .rst_n   (dom_rst_n),
    .run     (run),
    .exempt  (exempt),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
// Two-channel glitch-free clock stop controller.
module clk_stop_ctrl #(
  parameter int N_CPU       = 2,
  parameter int N_SDRAM     = 5,
  parameter int N_PCI       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CPU_OFF_LAT = 1,
  parameter int CPU_ON_LAT  = 1,
  parameter int CPU_MIN_ON  = 100,
  parameter int PCI_OFF_LAT = 1,
  parameter int PCI_ON_LAT  = 3,
  parameter int PCI_MIN_ON  = 10
) (
  input  logic               cpu_ref_clk,
  input  logic               pci_ref_clk,
  input  logic               rst_n,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               lane0_gated,
  output logic [N_CPU-1:0]   cpu_clk_out,
  output logic [N_SDRAM-1:0] sdram_clk_out,
  output logic [N_PCI-1:0]   pci_clk_out,
  output logic               pci_free_clk_out
);

  localparam int CPU_LANES = N_CPU + N_SDRAM;

  logic [CPU_LANES-1:0] cpu_exempt;
  logic [CPU_LANES-1:0] cpu_lanes;
  logic [N_PCI-1:0]     pci_exempt;
  logic                 cpu_run;
  logic                 pci_run;

  always_comb begin
    cpu_exempt        = '0;
    cpu_exempt[0]     = !lane0_gated;
    cpu_exempt[N_CPU] = !lane0_gated;
  end

  assign pci_exempt = '0;

  clkstop_channel #(
    .SYNC_STAGES (SYNC_STAGES),
    .OFF_LAT     (CPU_OFF_LAT),
    .ON_LAT      (CPU_ON_LAT),
    .MIN_ON      (CPU_MIN_ON),
    .LANES       (CPU_LANES)
  ) u_cpu_ch (
    .ref_clk (cpu_ref_clk),
    .rst_n   (rst_n),
    .stop_n  (cpu_stop_n),
    .exempt  (cpu_exempt),
    .clk_out (cpu_lanes),
    .run     (cpu_run)
  );

  clkstop_channel #(
    .SYNC_STAGES (SYNC_STAGES),
    .OFF_LAT     (PCI_OFF_LAT),
    .ON_LAT      (PCI_ON_LAT),
    .MIN_ON      (PCI_MIN_ON),
    .LANES       (N_PCI)
  ) u_pci_ch (
    .ref_clk (pci_ref_clk),
    .rst_n   (rst_n),
    .stop_n  (pci_stop_n),
    .exempt  (pci_exempt),
    .clk_out (pci_clk_out),
    .run     (pci_run)
  );

  assign cpu_clk_out      = cpu_lanes[N_CPU-1:0];
  assign sdram_clk_out    = cpu_lanes[CPU_LANES-1:N_CPU];
  assign pci_free_clk_out = pci_ref_clk;

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
// Assertion checker bound to clk_stop_ctrl.
module clk_stop_ctrl_chk #(
  parameter int N_CPU       = 2,
  parameter int N_SDRAM     = 5,
  parameter int N_PCI       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CPU_MIN_ON  = 100,
  parameter int PCI_MIN_ON  = 10
) (
  input logic               cpu_ref_clk,
  input logic               pci_ref_clk,
  input logic               rst_n,
  input logic               cpu_stop_n,
  input logic               pci_stop_n,
  input logic               cpu_run,
  input logic               pci_run,
  input logic [N_CPU-1:0]   cpu_clk_out,
  input logic [N_SDRAM-1:0] sdram_clk_out,
  input logic [N_PCI-1:0]   pci_clk_out
);

  localparam int CWW = $clog2(CPU_MIN_ON + 2);
  localparam int PWW = $clog2(PCI_MIN_ON + 2);

  logic [CWW-1:0] cpu_up_cnt;
  logic [PWW-1:0] pci_up_cnt;
  logic           cpu_run_d, pci_run_d;

  always_ff @(posedge cpu_ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_up_cnt <= CWW'(CPU_MIN_ON);
      cpu_run_d  <= 1'b1;
    end else begin
      cpu_run_d <= cpu_run;
      if (cpu_run && !cpu_run_d)                        cpu_up_cnt <= CWW'(1);
      else if (cpu_run && cpu_up_cnt < CWW'(CPU_MIN_ON)) cpu_up_cnt <= cpu_up_cnt + CWW'(1);
    end
  end

  always_ff @(posedge pci_ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_up_cnt <= PWW'(PCI_MIN_ON);
      pci_run_d  <= 1'b1;
    end else begin
      pci_run_d <= pci_run;
      if (pci_run && !pci_run_d)                        pci_up_cnt <= PWW'(1);
      else if (pci_run && pci_up_cnt < PWW'(PCI_MIN_ON)) pci_up_cnt <= pci_up_cnt + PWW'(1);
    end
  end

  AST_CPU_HALT_NEEDS_REQ: assert property (@(posedge cpu_ref_clk) disable iff (!rst_n)
    $fell(cpu_run) |-> !$past(cpu_stop_n, SYNC_STAGES + 1)); // R2

  AST_CPU_WAKE_NEEDS_RELEASE: assert property (@(posedge cpu_ref_clk) disable iff (!rst_n)
    $rose(cpu_run) |-> $past(cpu_stop_n, SYNC_STAGES + 1)); // R4

  AST_CPU_MIN_WINDOW: assert property (@(posedge cpu_ref_clk) disable iff (!rst_n)
    $fell(cpu_run) |-> (cpu_up_cnt >= CWW'(CPU_MIN_ON))); // R6

  AST_CPU_GROUP_AGREE: assert property (@(negedge cpu_ref_clk) disable iff (!rst_n)
    cpu_clk_out[N_CPU-1] == sdram_clk_out[N_SDRAM-1]); // R3

  AST_PCI_HALT_NEEDS_REQ: assert property (@(posedge pci_ref_clk) disable iff (!rst_n)
    $fell(pci_run) |-> !$past(pci_stop_n, SYNC_STAGES + 1)); // R8

  AST_PCI_MIN_WINDOW: assert property (@(posedge pci_ref_clk) disable iff (!rst_n)
    $fell(pci_run) |-> (pci_up_cnt >= PWW'(PCI_MIN_ON))); // R9

  AST_PCI_LANES_AGREE: assert property (@(negedge pci_ref_clk) disable iff (!rst_n)
    ($countones(pci_clk_out) == 0) || ($countones(pci_clk_out) == N_PCI)); // R8

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .N_CPU       (N_CPU),
  .N_SDRAM     (N_SDRAM),
  .N_PCI       (N_PCI),
  .SYNC_STAGES (SYNC_STAGES),
  .CPU_MIN_ON  (CPU_MIN_ON),
  .PCI_MIN_ON  (PCI_MIN_ON)
) u_chk (
  .cpu_ref_clk   (cpu_ref_clk),
  .pci_ref_clk   (pci_ref_clk),
  .rst_n         (rst_n),
  .cpu_stop_n    (cpu_stop_n),
  .pci_stop_n    (pci_stop_n),
  .cpu_run       (cpu_run),
  .pci_run       (pci_run),
  .cpu_clk_out   (cpu_clk_out),
  .sdram_clk_out (sdram_clk_out),
  .pci_clk_out   (pci_clk_out)
);

// File: tb/test_clk_stop_ctrl.sv
`timescale 1ns/1ps
module test_clk_stop_ctrl;

  localparam int N_CPU = 2, N_SDRAM = 5, N_PCI = 2, SYNC = 2;
  localparam int C_OFF = 1, C_ON = 1, C_MIN = 100;
  localparam int P_OFF = 1, P_ON = 3, P_MIN = 10;
  localparam real C_HALF = 10.0, P_HALF = 15.0;

  logic cpu_ref_clk, pci_ref_clk, rst_n, cpu_stop_n, pci_stop_n, lane0_gated;
  logic [N_CPU-1:0]   cpu_clk_out;
  logic [N_SDRAM-1:0] sdram_clk_out;
  logic [N_PCI-1:0]   pci_clk_out;
  logic               pci_free_clk_out;

  int checks = 0, failures = 0;
  bit done = 0;

  clk_stop_ctrl i_clk_stop_ctrl (
    .cpu_ref_clk(cpu_ref_clk), .pci_ref_clk(pci_ref_clk), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .lane0_gated(lane0_gated),
    .cpu_clk_out(cpu_clk_out), .sdram_clk_out(sdram_clk_out),
    .pci_clk_out(pci_clk_out), .pci_free_clk_out(pci_free_clk_out));

  initial begin cpu_ref_clk = 0; forever #10 cpu_ref_clk = ~cpu_ref_clk; end
  initial begin pci_ref_clk = 0; #3; forever #15 pci_ref_clk = ~pci_ref_clk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulses seen on a stoppable CPU lane until the first missing one
  task automatic cpu_count_pulses(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge cpu_ref_clk); #1;
      if (cpu_clk_out[1]) n++; else break;
    end
  endtask

  task automatic pci_count_pulses(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge pci_ref_clk); #1;
      if (pci_clk_out[0]) n++; else break;
    end
  endtask

  task automatic t_reset;
    rst_n = 0; cpu_stop_n = 1; pci_stop_n = 1; lane0_gated = 1;
    repeat (4) @(posedge cpu_ref_clk);
    #1;
    chk(cpu_clk_out == 0 && sdram_clk_out == 0, "R1 cpu/sdram low in reset",
        int'({cpu_clk_out, sdram_clk_out}), 0);
    @(posedge pci_ref_clk); #1;
    chk(pci_clk_out == 0, "R1 pci low in reset", int'(pci_clk_out), 0);
    rst_n = 1;
    repeat (6) @(posedge cpu_ref_clk);
    #1;
    chk(cpu_clk_out[1] && sdram_clk_out[N_SDRAM-1], "R1 cpu running after reset",
        int'(cpu_clk_out[1]), 1);
    @(posedge pci_ref_clk); #1;
    chk(pci_clk_out[0], "R1 pci running after reset", int'(pci_clk_out[0]), 1);
  endtask

  task automatic t_cpu_stop;
    int n;
    bit low_ok, pci_ok;
    @(negedge cpu_ref_clk); #2 cpu_stop_n = 0;
    cpu_count_pulses(n);
    chk(n == SYNC + C_OFF, "R2 cpu off latency pulses", n, SYNC + C_OFF);
    low_ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(posedge cpu_ref_clk); #1;
      if (cpu_clk_out != 0 || sdram_clk_out != 0) low_ok = 0;
    end
    chk(low_ok, "R3 cpu/sdram held low (lane0 gated, R7)", int'(low_ok), 1);
    pci_ok = 1;
    for (int i = 0; i < 6; i++) begin
      @(posedge pci_ref_clk); #1;
      if (pci_clk_out != '1 || !pci_free_clk_out) pci_ok = 0;
    end
    chk(pci_ok, "R10 pci undisturbed by cpu stop", int'(pci_ok), 1);
  endtask

  task automatic cpu_release_measure;
    int k;
    realtime t_up, t_dn;
    k = 0; t_up = 0;
    @(negedge cpu_ref_clk); #2 cpu_stop_n = 1;
    for (int i = 1; i < 50; i++) begin
      @(posedge cpu_ref_clk); t_up = $realtime; #1;
      if (cpu_clk_out[1]) begin k = i; break; end
    end
    chk(k == SYNC + C_ON + 1, "R4 cpu first pulse edge", k, SYNC + C_ON + 1);
    @(negedge cpu_clk_out[1]); t_dn = $realtime;
    chk((t_dn - t_up) == C_HALF, "R5 cpu first pulse width ns",
        int'(t_dn - t_up), int'(C_HALF));
  endtask

  task automatic t_cpu_window;
    int n;
    cpu_release_measure();
    #2 cpu_stop_n = 0;
    cpu_count_pulses(n);
    n = n + 1;
    chk(n == C_MIN + C_OFF, "R6 cpu pulses with pending stop", n, C_MIN + C_OFF);
  endtask

  task automatic t_cpu_exempt;
    bit ok;
    cpu_release_measure();
    repeat (C_MIN + 10) @(posedge cpu_ref_clk);
    @(negedge cpu_ref_clk); lane0_gated = 0;
    #2 cpu_stop_n = 0;
    repeat (SYNC + C_OFF + 3) @(posedge cpu_ref_clk);
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      @(posedge cpu_ref_clk); #1;
      if (!cpu_clk_out[0] || !sdram_clk_out[0]) ok = 0;
      if (cpu_clk_out[1] || sdram_clk_out[1]) ok = 0;
    end
    chk(ok, "R7 lane0 free when strap 0, others stopped", int'(ok), 1);
    @(negedge cpu_ref_clk); #2 cpu_stop_n = 1;
    repeat (C_MIN + 10) @(posedge cpu_ref_clk);
    @(negedge cpu_ref_clk); lane0_gated = 1;
  endtask

  task automatic t_pci;
    int n, k;
    bit ok;
    realtime t_up, t_dn;
    @(negedge pci_ref_clk); #2 pci_stop_n = 0;
    pci_count_pulses(n);
    chk(n == SYNC + P_OFF, "R8 pci off latency pulses", n, SYNC + P_OFF);
    ok = 1;
    for (int i = 0; i < 8; i++) begin
      @(posedge pci_ref_clk); #1;
      if (pci_clk_out != 0 || !pci_free_clk_out) ok = 0;
    end
    chk(ok, "R3 pci held low, R10 free pci runs", int'(ok), 1);
    ok = 1;
    for (int i = 0; i < 8; i++) begin
      @(posedge cpu_ref_clk); #1;
      if (!cpu_clk_out[1] || !sdram_clk_out[1]) ok = 0;
    end
    chk(ok, "R10 cpu undisturbed by pci stop", int'(ok), 1);
    k = 0; t_up = 0;
    @(negedge pci_ref_clk); #2 pci_stop_n = 1;
    for (int i = 1; i < 50; i++) begin
      @(posedge pci_ref_clk); t_up = $realtime; #1;
      if (pci_clk_out[0]) begin k = i; break; end
    end
    chk(k == SYNC + P_ON + 1, "R8 pci first pulse edge", k, SYNC + P_ON + 1);
    @(negedge pci_clk_out[0]); t_dn = $realtime;
    chk((t_dn - t_up) == P_HALF, "R5 pci first pulse width ns",
        int'(t_dn - t_up), int'(P_HALF));
    #2 pci_stop_n = 0;
    pci_count_pulses(n);
    n = n + 1;
    chk(n == P_MIN + P_OFF, "R9 pci pulses with pending stop", n, P_MIN + P_OFF);
    @(negedge pci_ref_clk); #2 pci_stop_n = 1;
    repeat (P_MIN + 8) @(posedge pci_ref_clk);
  endtask

  initial begin
    t_reset();
    t_cpu_stop();
    t_cpu_window();
    t_cpu_exempt();
    t_cpu_stop();
    cpu_release_measure();
    t_pci();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule